// File: doc/BRIEF.md
# Configuration Image Checksum Verifier

This block validates a configuration image that arrives as a stream of 16-bit words, for example while it is read out of a serial PROM or a one-time-programmable region at boot. A start pulse opens an image. Each following word presented with a valid strobe is folded into an 8-bit CRC, and a last-word flag closes the image. The CRC covers every byte of the image except the upper byte of the closing word, because that byte carries the checksum the image expects.

When the closing word has been taken, the block reports the computed checksum, whether it matches the embedded one, the format revision found in the lower byte of the closing word, and whether that revision is one of the two accepted values. It also reports whether the word count equals the configured image length. The verdict is held until the next start pulse, so the boot logic can sample it at any time after the one-cycle completion pulse.

Top module: `cfg_image_crc_check`

## Requirements
- R1: While reset is asserted and after it is released, done_o, crc_ok_o, rev_ok_o and length_err_o are 0 and crc_o and rev_o read 0x00.
- R2: crc_o is the CRC with generator x^8+x^7+x^6+x^4+x^2+1, applied least-significant bit first (reflected constant 0xAB) and preset to 0xFF. Each word contributes bits 7:0 and then bits 15:8, except the closing word, which contributes bits 7:0 only. The register is then XORed with 0xFF.
- R3: crc_ok_o is 1 exactly when crc_o equals bits 15:8 of the closing word.
- R4: rev_o equals bits 7:0 of the closing word. rev_ok_o is 1 only when crc_ok_o is 1 and rev_o is 8 or 9.
- R5: done_o is high for exactly one cycle, the cycle that follows the clock edge at which the closing word was taken.
- R6: All result outputs hold their values until the next start pulse. The cycle after a start pulse, all flags and crc_o and rev_o are 0.
- R7: length_err_o is 1 when the number of words taken, the closing one included, differs from IMG_WORDS.
- R8: A start pulse during an image drops the words seen so far and re-presets the CRC. The result then depends only on the words that follow it.
- R9: Words are ignored when word_valid_i is low, before the first start pulse, and after the closing word until the next start.
- R10: A word presented in the same cycle as the start pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new image and presets the CRC |
| word_valid_i | input | 1 | word_i carries an image word this cycle |
| word_i | input | 16 | Image word |
| last_i | input | 1 | Marks the closing word, qualified by word_valid_i |
| done_o | output | 1 | One-cycle pulse when a verdict is ready |
| crc_ok_o | output | 1 | Computed checksum equals the embedded one |
| rev_ok_o | output | 1 | Checksum good and revision accepted |
| length_err_o | output | 1 | Word count differs from IMG_WORDS |
| crc_o | output | 8 | Computed checksum |
| rev_o | output | 8 | Revision byte of the closing word |

## Verification
The bench uses a four-word image. It first sweeps the revision byte through all 256 values with a correct checksum, which separates the two accepted revisions from all others and confirms that the checksum ignores the upper byte of the closing word. It then sweeps all 255 wrong checksum values and flips each single bit of the image. These runs show that every corruption drops crc_ok_o, and that crc_o tracks the flipped contents, which catches a wrong polynomial, a wrong byte order or a wrong preset. Further runs with short and long images, idle gaps, an aborting restart, stray words and a word sharing the start cycle separate the length, abort and ignore rules from the CRC path.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;

    localparam int unsigned CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'hAB;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 8'hFF;
    localparam logic [CRC_W-1:0] CRC_XOR_OUT   = 8'hFF;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/crc8_byte_update.sv
// One byte through a reflected (LSB-first) CRC register, unrolled bit by bit.
module crc8_byte_update
    import cfgcrc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       data_i,
    output logic [CRC_W-1:0] crc_o
);
    localparam int unsigned NBITS = 8;

    logic [CRC_W-1:0] stage [0:NBITS];

    assign stage[0] = crc_i ^ data_i;

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY)
                                        : (stage[b] >> 1);
    end

    assign crc_o = stage[NBITS];

endmodule

// File: rtl/crc8_word_step.sv
// Folds one 16-bit word, low byte then high byte, in one cycle.
// Also offers the result after the low byte alone, for the closing word.
module crc8_word_step
    import cfgcrc_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic [15:0]      word_i,
    output logic [CRC_W-1:0] crc_low_o,
    output logic [CRC_W-1:0] crc_full_o
);
    logic [CRC_W-1:0] after_low;

    crc8_byte_update #(.POLY(CRC_POLY_REFL)) u_low (
        .crc_i  (crc_i),
        .data_i (word_i[7:0]),
        .crc_o  (after_low)
    );

    crc8_byte_update #(.POLY(CRC_POLY_REFL)) u_high (
        .crc_i  (after_low),
        .data_i (word_i[15:8]),
        .crc_o  (crc_full_o)
    );

    assign crc_low_o = after_low;

endmodule

// File: rtl/img_length_tracker.sv
// Counts accepted words and tells whether the current word, if it
// closes the image, makes the length differ from the target.
module img_length_tracker #(
    parameter int unsigned IMG_WORDS = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic len_bad_o
);
    localparam int unsigned CNT_W = $clog2(IMG_WORDS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LEN_TGT = CNT_W'(IMG_WORDS);

    logic [CNT_W-1:0] count_d, count_q;
    logic [CNT_W-1:0] count_incl;

    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (inc_i && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_incl = (count_q == CNT_MAX) ? CNT_MAX : CNT_W'(count_q + 1'b1);
    assign len_bad_o  = (count_incl != LEN_TGT);

endmodule

// File: rtl/cfg_image_crc_check.sv
module cfg_image_crc_check
    import cfgcrc_pkg::*;
#(
    parameter int unsigned IMG_WORDS = 220,
    parameter logic [7:0]  REV_A     = 8'd8,
    parameter logic [7:0]  REV_B     = 8'd9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        word_valid_i,
    input  logic [15:0] word_i,
    input  logic        last_i,
    output logic        done_o,
    output logic        crc_ok_o,
    output logic        rev_ok_o,
    output logic        length_err_o,
    output logic [7:0]  crc_o,
    output logic [7:0]  rev_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CRC_W-1:0] crc;
        logic             done;
        logic             crc_ok;
        logic             rev_ok;
        logic             len_err;
        logic [CRC_W-1:0] crc_res;
        logic [7:0]       rev_res;
    } state_t;

    localparam state_t STATE_RST = '{
        phase:   PH_IDLE,
        crc:     CRC_PRESET,
        done:    1'b0,
        crc_ok:  1'b0,
        rev_ok:  1'b0,
        len_err: 1'b0,
        crc_res: '0,
        rev_res: '0
    };

    state_t st_d, st_q;

    logic             accept;
    logic [CRC_W-1:0] crc_low, crc_full;
    logic [CRC_W-1:0] final_sum;
    logic             sum_match;
    logic             rev_known;
    logic             len_bad;

    assign accept = (st_q.phase == PH_RUN) && word_valid_i && !start_i;

    crc8_word_step u_step (
        .crc_i      (st_q.crc),
        .word_i     (word_i),
        .crc_low_o  (crc_low),
        .crc_full_o (crc_full)
    );

    img_length_tracker #(.IMG_WORDS(IMG_WORDS)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .inc_i     (accept),
        .len_bad_o (len_bad)
    );

    assign final_sum = crc_low ^ CRC_XOR_OUT;
    assign sum_match = (final_sum == word_i[15:8]);
    assign rev_known = (word_i[7:0] == REV_A) || (word_i[7:0] == REV_B);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.phase   = PH_RUN;
            st_d.crc     = CRC_PRESET;
            st_d.crc_ok  = 1'b0;
            st_d.rev_ok  = 1'b0;
            st_d.len_err = 1'b0;
            st_d.crc_res = '0;
            st_d.rev_res = '0;
        end else if (accept) begin
            if (last_i) begin
                st_d.phase   = PH_IDLE;
                st_d.crc     = crc_low;
                st_d.done    = 1'b1;
                st_d.crc_res = final_sum;
                st_d.crc_ok  = sum_match;
                st_d.rev_res = word_i[7:0];
                st_d.rev_ok  = sum_match && rev_known;
                st_d.len_err = len_bad;
            end else begin
                st_d.crc = crc_full;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o       = st_q.done;
    assign crc_ok_o     = st_q.crc_ok;
    assign rev_ok_o     = st_q.rev_ok;
    assign length_err_o = st_q.len_err;
    assign crc_o        = st_q.crc_res;
    assign rev_o        = st_q.rev_res;

endmodule

// File: rtl/cfg_image_crc_check_sva.sv
module cfg_image_crc_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        word_valid_i,
    input logic        last_i,
    input logic        done_o,
    input logic        crc_ok_o,
    input logic        rev_ok_o,
    input logic        length_err_o,
    input logic [7:0]  crc_o,
    input logic [7:0]  rev_o
);
    // R5: completion lasts a single cycle
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: completion only after a closing word was presented
    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(word_valid_i && last_i && !start_i));

    // R4: revision accepted only with a good checksum
    assert_rev_needs_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rev_ok_o |-> crc_ok_o);

    // R6: a start pulse clears the verdict
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!crc_ok_o && !rev_ok_o && !length_err_o && !done_o
                     && crc_o == 8'h00 && rev_o == 8'h00));

    // R6: verdict holds unless a start or a completion intervenes
    assert_verdict_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && !done_o) |->
            ($stable(crc_o) && $stable(rev_o) && $stable(crc_ok_o)
             && $stable(rev_ok_o) && $stable(length_err_o)));

endmodule

bind cfg_image_crc_check cfg_image_crc_check_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .word_valid_i (word_valid_i),
    .last_i       (last_i),
    .done_o       (done_o),
    .crc_ok_o     (crc_ok_o),
    .rev_ok_o     (rev_ok_o),
    .length_err_o (length_err_o),
    .crc_o        (crc_o),
    .rev_o        (rev_o)
);

// File: tb/tb_cfg_image_crc_check.sv
module tb_cfg_image_crc_check;
    localparam int CLK_P = 10;
    localparam int NW    = 4;
    localparam int MAXW  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        last_i = 1'b0;
    logic        done_o, crc_ok_o, rev_ok_o, length_err_o;
    logic [7:0]  crc_o, rev_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] img [0:MAXW-1];

    always #(CLK_P/2) clk = ~clk;

    cfg_image_crc_check #(.IMG_WORDS(NW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .word_valid_i(word_valid_i), .word_i(word_i), .last_i(last_i),
        .done_o(done_o), .crc_ok_o(crc_ok_o), .rev_ok_o(rev_ok_o),
        .length_err_o(length_err_o), .crc_o(crc_o), .rev_o(rev_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] feed(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 8'hAB) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] ref_sum(input int n);
        logic [7:0] c;
        c = 8'hFF;
        for (int i = 0; i < n - 1; i++) begin
            c = feed(c, img[i][7:0]);
            c = feed(c, img[i][15:8]);
        end
        c = feed(c, img[n-1][7:0]);
        return c ^ 8'hFF;
    endfunction

    task automatic fill(input int n, input logic [15:0] seed, input logic [7:0] rev);
        logic [15:0] s;
        s = seed;
        for (int i = 0; i < n; i++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]} ^ 16'h1357;
            img[i] = s;
        end
        img[n-1][7:0] = rev;
        img[n-1][15:8] = ref_sum(n);
    endtask

    // After return, we sit at the negedge right after the closing word's edge.
    task automatic send(input int n, input bit gaps, input bit word_at_start);
        @(negedge clk);
        start_i = 1'b1;
        word_valid_i = word_at_start;
        word_i = 16'hDEAD;
        last_i = word_at_start;
        @(negedge clk);
        start_i = 1'b0;
        word_valid_i = 1'b0;
        last_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                word_i = 16'hFFFF;
                @(negedge clk);
            end
            word_valid_i = 1'b1;
            word_i = img[i];
            last_i = (i == n - 1);
            @(negedge clk);
            word_valid_i = 1'b0;
            last_i = 1'b0;
        end
    endtask

    task automatic check_verdict(input string tag, input int n, input bit exp_len_err);
        logic [7:0] exp_sum;
        logic       exp_ok;
        exp_sum = ref_sum(n);
        exp_ok  = (exp_sum == img[n-1][15:8]);
        check({tag, " R5 done"}, done_o, 1);
        check({tag, " R2 crc"}, crc_o, exp_sum);
        check({tag, " R3 crc_ok"}, crc_ok_o, exp_ok);
        check({tag, " R4 rev"}, rev_o, img[n-1][7:0]);
        check({tag, " R4 rev_ok"}, rev_ok_o,
              exp_ok && (img[n-1][7:0] == 8'd8 || img[n-1][7:0] == 8'd9));
        check({tag, " R7 len"}, length_err_o, exp_len_err);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] good;
        // R1 reset state
        #(CLK_P * 3);
        @(negedge clk);
        check("R1 flags in reset", {done_o, crc_ok_o, rev_ok_o, length_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", {done_o, crc_ok_o, rev_ok_o, length_err_o}, 0);
        check("R1 crc/rev after reset", {crc_o, rev_o}, 0);

        // R9: word before any start is ignored
        word_valid_i = 1'b1; last_i = 1'b1; word_i = 16'h0908;
        @(negedge clk);
        word_valid_i = 1'b0; last_i = 1'b0;
        @(negedge clk);
        check("R9 no verdict before start", {done_o, crc_ok_o, crc_o, rev_o}, 0);

        // Revision sweep with correct checksum (R2 R3 R4 R5 R6 R9)
        for (int r = 0; r < 256; r++) begin
            fill(NW, 16'(r * 37 + 5), 8'(r));
            send(NW, r[0], 1'b0);
            check_verdict("rev sweep", NW, 0);
            @(negedge clk);
            check("R5 done falls", done_o, 0);
            check("R6 hold crc_ok", crc_ok_o, 1);
        end

        // Wrong embedded checksum sweep (R3)
        fill(NW, 16'hACE1, 8'd8);
        good = img[NW-1][15:8];
        for (int k = 1; k < 256; k++) begin
            img[NW-1][15:8] = good ^ 8'(k);
            send(NW, 1'b0, 1'b0);
            check_verdict("bad sum R3", NW, 0);
            check("R3 mismatch", crc_ok_o, 0);
        end

        // Single bit flips of the covered bits (R2 R3)
        for (int w = 0; w < NW; w++) begin
            for (int b = 0; b < 16; b++) begin
                if (!(w == NW - 1 && b >= 8)) begin
                    fill(NW, 16'h5A5A, 8'd9);
                    img[w][b] = ~img[w][b];
                    send(NW, 1'b0, 1'b0);
                    check_verdict("flip R2", NW, 0);
                    check("R3 flip detected", crc_ok_o, 0);
                end
            end
        end

        // Length errors (R7)
        fill(NW - 1, 16'h1111, 8'd8);
        send(NW - 1, 1'b0, 1'b0);
        check_verdict("short R7", NW - 1, 1);
        fill(NW + 1, 16'h2222, 8'd9);
        send(NW + 1, 1'b1, 1'b0);
        check_verdict("long R7", NW + 1, 1);

        // R9: words after the closing word are ignored
        word_valid_i = 1'b1; last_i = 1'b1; word_i = 16'h0000;
        @(negedge clk);
        word_valid_i = 1'b0; last_i = 1'b0;
        @(negedge clk);
        check("R9 stray word no done", done_o, 0);
        check("R9 stray word keeps len", length_err_o, 1);
        check("R9 stray word keeps rev", rev_o, img[NW][7:0]);

        // R10: word sharing the start cycle is ignored
        fill(NW, 16'h3333, 8'd8);
        send(NW, 1'b0, 1'b1);
        check_verdict("R10 start word", NW, 0);

        // R6: start clears the verdict
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 cleared flags", {done_o, crc_ok_o, rev_ok_o, length_err_o}, 0);
        check("R6 cleared values", {crc_o, rev_o}, 0);

        // R8: abort mid-image, then a clean image
        for (int i = 0; i < 2; i++) begin
            word_valid_i = 1'b1; word_i = 16'hBEEF ^ 16'(i);
            @(negedge clk);
        end
        word_valid_i = 1'b0;
        fill(NW, 16'h4444, 8'd9);
        send(NW, 1'b0, 1'b0);
        check_verdict("R8 abort", NW, 0);
        check("R8 clean result", {crc_ok_o, rev_ok_o}, 2'b11);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule